// File: doc/BRIEF.md
# Interrupt and Reset Vector Loader

This block decides where the processor fetches from after a reset and after an interrupt. Reset places the code segment at FFFFH and the instruction pointer at 0000H. The physical fetch position is the segment shifted left four bits plus the pointer, so reset points it at FFFF0H, near the top of the 1 MB space.

When an interrupt carrying an 8-bit type number n is taken, the block reads two 16-bit words through a word-read memory port. Both words come from the pointer table in the lowest kilobyte of memory. The word at 4n becomes the new instruction pointer. The word at 4n+2 becomes the new code segment. A one-cycle resume pulse then tells the core that it may continue from the new location. Pushing flags and the return address, arbitrating among interrupt sources and running acknowledge cycles are left to other blocks.

Top module: `vec_loader`

## Requirements
- R1: While reset is low and in the first cycle after it is released, cs_o is FFFFH, ip_o is 0000H, fetch_addr is FFFF0H, and both mem_req and busy are low.
- R2: fetch_addr always equals (cs_o*16 + ip_o) modulo 2^20.
- R3: If irq_req is high at a clock edge while busy is low, the block latches irq_type as n. In the next cycle it drives mem_req high with mem_addr = 4n, zero-extended to 20 bits, so every request falls within 00000H..003FFH.
- R4: Once the offset read is accepted (mem_req and mem_ready high), the next cycle issues a read at 4n+2.
- R5: While mem_req is high and mem_ready is low, mem_req and mem_addr hold their values into the next cycle.
- R6: Once the segment read is accepted, the next cycle has resume high and mem_req low. In the cycle after that, busy is low, ip_o holds the word read at 4n and cs_o holds the word read at 4n+2.
- R7: cs_o and ip_o keep their old values for the whole load, up to the end of the resume cycle.
- R8: While busy is high, irq_req and irq_type are ignored. The current type is not replaced, and no second load starts when the first one finishes.
- R9: Asserting reset in the middle of a load abandons it at once and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request, sampled while idle |
| irq_type | input | 8 | Interrupt type number |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 20 | Byte address of the word to read |
| mem_rdata | input | 16 | Read data, valid together with mem_ready |
| mem_ready | input | 1 | Read completes at this clock edge |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction pointer |
| fetch_addr | output | 20 | Physical fetch address |
| busy | output | 1 | A vector load is in progress |
| resume | output | 1 | One-cycle pulse: new cs_o/ip_o take effect next cycle |

## Verification
A corrupted latched type number appears at mem_addr in the first request cycle, so a wrong type is visible one cycle after the request. A sequencer that skips or repeats a state shows up within two cycles of a completed read, either as a wrong second address or as a missing or early resume pulse. A swapped or stale capture register is detectable only one cycle after resume, when cs_o, ip_o and fetch_addr fail to match the two words served. All 256 type numbers are swept with varying wait states so that every address bit and every capture path is exercised.

// File: rtl/vec_loader.sv
module vec_loader (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_req,
  input  logic [7:0]  irq_type,
  output logic        mem_req,
  output logic [19:0] mem_addr,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ready,
  output logic [15:0] cs_o,
  output logic [15:0] ip_o,
  output logic [19:0] fetch_addr,
  output logic        busy,
  output logic        resume
);
  localparam logic [15:0] BOOT_SEG = 16'hFFFF;
  localparam logic [15:0] BOOT_OFF = 16'h0000;

  typedef enum logic [1:0] {S_IDLE, S_OFF, S_SEG, S_LOAD} st_t;
  st_t st;
  logic [7:0]  vtype;
  logic [15:0] off_q, seg_q;

  assign busy     = (st != S_IDLE);
  assign resume   = (st == S_LOAD);
  assign mem_req  = (st == S_OFF) || (st == S_SEG);
  assign mem_addr = {10'd0, vtype, (st == S_SEG), 1'b0};
  assign fetch_addr = {cs_o, 4'h0} + {4'h0, ip_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      vtype <= '0;
      off_q <= '0;
      seg_q <= '0;
      cs_o  <= BOOT_SEG;
      ip_o  <= BOOT_OFF;
    end else begin
      case (st)
        S_IDLE: if (irq_req) begin
          vtype <= irq_type;
          st    <= S_OFF;
        end
        S_OFF: if (mem_ready) begin
          off_q <= mem_rdata;
          st    <= S_SEG;
        end
        S_SEG: if (mem_ready) begin
          seg_q <= mem_rdata;
          st    <= S_LOAD;
        end
        default: begin
          ip_o <= off_q;
          cs_o <= seg_q;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  AST_OFF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq_req) |=> (mem_req && mem_addr == {10'd0, $past(irq_type), 2'b00})); // R3
  AST_SEG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_addr[1]) |=> (mem_req && mem_addr == $past(mem_addr) + 20'd2)); // R4
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R5
  AST_RESUME_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_addr[1]) |=> (resume && !mem_req)); // R6
  AST_CSIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !resume) |=> ($stable(cs_o) && $stable(ip_o))); // R7
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> (!busy && !mem_req)); // R8
endmodule

// File: tb/sim_vec_loader.sv
module sim_vec_loader;
  logic clk = 0, rst_n = 0, irq_req = 0, mem_ready = 0;
  logic [7:0] irq_type = 0;
  logic mem_req, busy, resume;
  logic [19:0] mem_addr, fetch_addr;
  logic [15:0] mem_rdata, cs_o, ip_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] word_at(input logic [19:0] a);
    logic [15:0] p = a[15:0] * 16'h9E37;
    return p ^ 16'hA5C3 ^ {12'h0, a[19:16]};
  endfunction

  assign mem_rdata = word_at(mem_addr);

  vec_loader u0 (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_type(irq_type),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .cs_o(cs_o), .ip_o(ip_o), .fetch_addr(fetch_addr), .busy(busy), .resume(resume));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_boot(input string tag);
    chk(cs_o == 16'hFFFF, tag, cs_o, 16'hFFFF);
    chk(ip_o == 16'h0000, tag, ip_o, 0);
    chk(fetch_addr == 20'hFFFF0, tag, fetch_addr, 20'hFFFF0);
    chk(!mem_req && !busy, tag, {mem_req, busy}, 0);
  endtask

  task automatic chk_fetch;
    logic [19:0] e = {cs_o, 4'h0} + {4'h0, ip_o};
    chk(fetch_addr == e, "R2 fetch sum", fetch_addr, e);
  endtask

  // one read phase at address a with w wait cycles; extra irq noise if noisy
  task automatic phase(input logic [19:0] a, input int w, input logic [15:0] cs0,
                       input logic [15:0] ip0, input bit noisy, input logic [7:0] nt);
    for (int i = 0; i <= w; i++) begin
      mem_ready = (i == w);
      if (noisy) begin irq_req = 1; irq_type = nt; end
      chk(mem_req && mem_addr == a, (a[1] ? "R4 seg addr / R5 hold" : "R3 off addr / R5 hold"), mem_addr, a);
      chk(cs_o == cs0 && ip_o == ip0, "R7 cs/ip held", {cs_o, ip_o}, {cs0, ip0});
      @(negedge clk);
    end
    mem_ready = 0;
  endtask

  task automatic do_vec(input logic [7:0] n, input int w, input bit noisy);
    logic [19:0] base = {10'd0, n, 2'b00};
    logic [15:0] cs0 = cs_o, ip0 = ip_o;
    logic [15:0] eo = word_at(base), es = word_at(base + 20'd2);
    irq_req = 1; irq_type = n;
    @(negedge clk);
    irq_req = 0;
    phase(base, w, cs0, ip0, noisy, ~n);
    phase(base + 20'd2, (w + 1) % 3, cs0, ip0, noisy, ~n);
    chk(resume && !mem_req, "R6 resume pulse", {resume, mem_req}, 2'b10);
    chk(cs_o == cs0 && ip_o == ip0, "R7 cs/ip held in resume", {cs_o, ip_o}, {cs0, ip0});
    irq_req = 0;
    @(negedge clk);
    chk(ip_o == eo, "R6 ip loaded", ip_o, eo);
    chk(cs_o == es, "R6 cs loaded", cs_o, es);
    chk(!busy && !resume, "R6 idle after load", {busy, resume}, 0);
    chk_fetch();
    if (noisy) begin
      @(negedge clk);
      chk(!mem_req && !busy, "R8 no second load", {mem_req, busy}, 0);
    end
  endtask

  initial begin
    #5000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_boot("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    chk_boot("R1 after release");
    chk_fetch();
    for (int n = 0; n < 256; n++) do_vec(n[7:0], n % 3, 0);
    for (int n = 0; n < 256; n += 17) do_vec(n[7:0], 1, 1);
    irq_req = 1; irq_type = 8'h42;
    @(negedge clk);
    irq_req = 0;
    chk(busy && mem_addr == 20'h00108, "R3 type 42h", mem_addr, 20'h00108);
    rst_n = 0;
    #1;
    chk_boot("R9 abort");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_boot("R9 after abort");
    chk_fetch();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule